// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

The block turns one DMA transfer into a chained scatter-gather descriptor list. It is given the list base address, the byte offset of the transfer in its first page and the total byte count. It then takes the DMA address of each page, one per handshake, on a page stream. It writes 16-byte descriptors (64-bit address, 32-bit length, 32-bit flags) through a write port into a descriptor RAM. Descriptors form groups of `GRP_N` slots. In every group that is followed by another group, slot 0 is a chain descriptor that points at the next group. The last group carries no chain descriptor: its data descriptors start at slot 0, and an end-of-list descriptor follows them.

When a fragment starts at the byte just after the end of the previous fragment, it extends the previous data descriptor instead of taking a new slot. The block keeps the group currently being filled in registers. Each group is written to the RAM only once the block knows whether that group is the last one, so no descriptor is ever read back or moved. A one-cycle `done` pulse reports that the list is closed.

Top module: `sg_list_builder`

## Requirements
- R1: On `start`, the block consumes exactly ceil((`cfg_first_offs` + `cfg_total_size`) / 2^`PAGE_W`) page addresses, or none when `cfg_total_size` is 0. `pg_ready` is low outside a run.
- R2: The first fragment begins at page address + `cfg_first_offs` and has length min(size, page − offset). Each later fragment begins at offset 0 of its page and has length min(remaining, page). Data descriptors carry flags `FLAG_DATA` (default 32'h1).
- R3: A fragment whose start address equals the end address of the previous fragment is added to the length of the previous data descriptor. No new descriptor is written for it.
- R4: A group that is followed by another group g+1 holds a chain descriptor at slot 0, at index g·GRP_N. Its address is base + 16·GRP_N·(g+1), its length is 16·GRP_N (128 at the default) and its flags are `FLAG_CHAIN` (default 32'h2). That group's GRP_N−1 data descriptors occupy slots 1 to GRP_N−1, in fragment order.
- R5: The last group has no chain descriptor. Its k data descriptors occupy slots 0 to k−1, and the end-of-list descriptor is written at slot k. No other index is written.
- R6: When the final fragment merges into a group already holding GRP_N−1 data descriptors, that group is the last group. Its end-of-list descriptor goes in slot GRP_N−1, and no further group is opened.
- R7: The end-of-list descriptor has address 0, length 0 and flags `FLAG_END` (default 32'h4).
- R8: A transfer of size 0 writes only the end-of-list descriptor, at index 0.
- R9: `done` is high for exactly one cycle, in the cycle after the end-of-list write. A `start` raised during a run is ignored.
- R10: While reset is asserted, `desc_we`, `done` and `pg_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| cfg_list_base | input | ADDR_W | Byte address of descriptor index 0 |
| cfg_first_offs | input | PAGE_W | Byte offset of the transfer in its first page |
| cfg_total_size | input | SIZE_W | Transfer size in bytes |
| pg_valid | input | 1 | A page address is offered |
| pg_addr | input | ADDR_W | Page-aligned DMA address of the next page |
| pg_ready | output | 1 | The offered page address is taken this cycle |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | IDX_W | Descriptor index (9 bits at defaults) |
| desc_addr | output | ADDR_W | Descriptor address field |
| desc_len | output | LEN_W | Descriptor length field |
| desc_flags | output | FLAG_W | Descriptor flags field |
| done | output | 1 | One-cycle pulse after the end-of-list write |

## Verification
The bench targets the group boundaries:
- exactly GRP_N−1 fragments, where a design that always opens a group would leave a stray chain slot;
- GRP_N−1 fragments plus a merging page, where a design that opened a new group early would emit an empty group holding only a chain descriptor;
- fifteen fragments, where chain targets must advance for two groups.

Merging is driven with fully contiguous, pairwise contiguous and scattered pages, and with an offset first page that merges into its neighbour. A wrong merge rule shows up as extra descriptors or wrong lengths. A page offered after the last one must not be taken. A mid-run `start` with a different configuration must leave the list unchanged, and a size-0 transfer must produce a lone end marker.

// File: rtl/sg_list_pkg.sv
package sg_list_pkg;
  localparam int SGB_ENTRY_BYTES = 16;

  typedef enum logic [1:0] {
    SGB_IDLE,
    SGB_TAKE,
    SGB_SPILL,
    SGB_CLOSE
  } sgb_state_t;
endpackage

// File: rtl/sg_frag_calc.sv
module sg_frag_calc #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int PAGE_W = 12
) (
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [PAGE_W-1:0] map_offs,
  input  logic [LEN_W-1:0]  rem,
  input  logic [ADDR_W-1:0] prev_end,
  input  logic              have_prev,
  output logic [ADDR_W-1:0] frag_addr,
  output logic [LEN_W-1:0]  frag_len,
  output logic              is_merge
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [LEN_W-1:0] avail;

  always_comb begin
    avail     = LEN_W'(PAGE_BYTES) - LEN_W'(map_offs);
    frag_addr = pg_addr + ADDR_W'(map_offs);
    frag_len  = (rem < avail) ? rem : avail;
    is_merge  = have_prev && (frag_addr == prev_end);
  end
endmodule

// File: rtl/sg_group_buf.sv
module sg_group_buf #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int DEPTH  = 7,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              merge,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [CNT_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic [CNT_W-1:0]  cnt
);
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [LEN_W-1:0]  ent_len  [DEPTH];
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (push) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (cnt == CNT_W'(i))) begin
        ent_addr[i] <= in_addr;
        ent_len[i]  <= in_len;
      end else if (merge && (cnt == CNT_W'(i + 1))) begin
        ent_len[i]  <= ent_len[i] + in_len;
      end
    end
  end

  assign rd_addr = ent_addr[rd_sel];
  assign rd_len  = ent_len[rd_sel];
endmodule

// File: rtl/sg_list_builder.sv
module sg_list_builder
  import sg_list_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          LEN_W      = 32,
  parameter int          FLAG_W     = 32,
  parameter int          PAGE_W     = 12,
  parameter int          SIZE_W     = 20,
  parameter int          GRP_N      = 8,
  parameter logic [31:0] FLAG_DATA  = 32'h0000_0001,
  parameter logic [31:0] FLAG_CHAIN = 32'h0000_0002,
  parameter logic [31:0] FLAG_END   = 32'h0000_0004,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int MAX_PAGES  = ((1 << SIZE_W) + 2 * PAGE_BYTES - 2) / PAGE_BYTES,
  localparam int MAX_ENT    = MAX_PAGES + MAX_PAGES / (GRP_N - 1) + 1,
  localparam int IDX_W      = $clog2(MAX_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_list_base,
  input  logic [PAGE_W-1:0] cfg_first_offs,
  input  logic [SIZE_W-1:0] cfg_total_size,
  input  logic              pg_valid,
  input  logic [ADDR_W-1:0] pg_addr,
  output logic              pg_ready,
  output logic              desc_we,
  output logic [IDX_W-1:0]  desc_idx,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [LEN_W-1:0]  desc_len,
  output logic [FLAG_W-1:0] desc_flags,
  output logic              done
);
  localparam int SLOT_W    = $clog2(GRP_N);
  localparam int GRP_W     = IDX_W - SLOT_W;
  localparam int BUF_N     = GRP_N - 1;
  localparam int GRP_BYTES = GRP_N * SGB_ENTRY_BYTES;
  localparam int GRP_SH    = $clog2(GRP_BYTES);
  localparam int PGCNT_W   = $clog2(MAX_PAGES + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  sgb_state_t         state_q, state_d;
  logic [ADDR_W-1:0]  base_q, base_d, prev_end_q, prev_end_d;
  logic [LEN_W-1:0]   rem_q, rem_d;
  logic [PAGE_W-1:0]  offs_q, offs_d;
  logic [PGCNT_W-1:0] pg_left_q, pg_left_d, pages_calc;
  logic [GRP_W-1:0]   grp_q, grp_d;
  logic [SLOT_W-1:0]  ptr_q, ptr_d, rd_sel, buf_cnt;
  logic               have_prev_q, have_prev_d, done_d;
  logic               push, merge, clr, need_spill, is_merge;
  logic [ADDR_W-1:0]  frag_addr, rd_addr;
  logic [LEN_W-1:0]   frag_len, rd_len;
  logic [SIZE_W+1:0]  span_up;

  sg_frag_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_frag (
    .pg_addr   (pg_addr),
    .map_offs  (offs_q),
    .rem       (rem_q),
    .prev_end  (prev_end_q),
    .have_prev (have_prev_q && (buf_cnt != '0)),
    .frag_addr (frag_addr),
    .frag_len  (frag_len),
    .is_merge  (is_merge)
  );

  sg_group_buf #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(BUF_N), .CNT_W(SLOT_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (clr),
    .push    (push),
    .merge   (merge),
    .in_addr (frag_addr),
    .in_len  (frag_len),
    .rd_sel  (rd_sel),
    .rd_addr (rd_addr),
    .rd_len  (rd_len),
    .cnt     (buf_cnt)
  );

  always_comb begin
    span_up    = (SIZE_W+2)'(cfg_total_size) + (SIZE_W+2)'(cfg_first_offs)
               + (SIZE_W+2)'(PAGE_BYTES - 1);
    pages_calc = (cfg_total_size == '0) ? '0 : PGCNT_W'(span_up >> PAGE_W);
    need_spill = pg_valid && !is_merge && (buf_cnt == SLOT_W'(BUF_N));
  end

  always_comb begin
    state_d     = state_q;
    base_d      = base_q;
    rem_d       = rem_q;
    offs_d      = offs_q;
    pg_left_d   = pg_left_q;
    grp_d       = grp_q;
    ptr_d       = ptr_q;
    prev_end_d  = prev_end_q;
    have_prev_d = have_prev_q;
    done_d      = 1'b0;
    pg_ready    = 1'b0;
    push        = 1'b0;
    merge       = 1'b0;
    clr         = 1'b0;
    rd_sel      = '0;
    desc_we     = 1'b0;
    desc_idx    = {grp_q, ptr_q};
    desc_addr   = '0;
    desc_len    = '0;
    desc_flags  = '0;
    unique case (state_q)
      SGB_IDLE: if (start) begin
        base_d      = cfg_list_base;
        rem_d       = LEN_W'(cfg_total_size);
        offs_d      = cfg_first_offs;
        pg_left_d   = pages_calc;
        grp_d       = '0;
        ptr_d       = '0;
        have_prev_d = 1'b0;
        clr         = 1'b1;
        state_d     = (pages_calc == '0) ? SGB_CLOSE : SGB_TAKE;
      end
      SGB_TAKE: begin
        pg_ready = !need_spill;
        if (need_spill) begin
          state_d = SGB_SPILL;
          ptr_d   = '0;
        end else if (pg_valid) begin
          push        = !is_merge;
          merge       = is_merge;
          rem_d       = rem_q - frag_len;
          pg_left_d   = pg_left_q - PGCNT_W'(1);
          offs_d      = '0;
          prev_end_d  = frag_addr + ADDR_W'(frag_len);
          have_prev_d = 1'b1;
          if (pg_left_q == PGCNT_W'(1)) begin
            state_d = SGB_CLOSE;
            ptr_d   = '0;
          end
        end
      end
      SGB_SPILL: begin
        desc_we = 1'b1;
        if (ptr_q == '0) begin
          desc_addr  = base_q + ((ADDR_W'(grp_q) + ADDR_W'(1)) << GRP_SH);
          desc_len   = LEN_W'(GRP_BYTES);
          desc_flags = FLAG_W'(FLAG_CHAIN);
        end else begin
          rd_sel     = ptr_q - SLOT_W'(1);
          desc_addr  = rd_addr;
          desc_len   = rd_len;
          desc_flags = FLAG_W'(FLAG_DATA);
        end
        if (ptr_q == SLOT_W'(GRP_N - 1)) begin
          grp_d   = grp_q + GRP_W'(1);
          clr     = 1'b1;
          state_d = SGB_TAKE;
        end else begin
          ptr_d = ptr_q + SLOT_W'(1);
        end
      end
      SGB_CLOSE: begin
        desc_we = 1'b1;
        if (ptr_q == buf_cnt) begin
          desc_flags = FLAG_W'(FLAG_END);
          done_d     = 1'b1;
          state_d    = SGB_IDLE;
        end else begin
          rd_sel     = ptr_q;
          desc_addr  = rd_addr;
          desc_len   = rd_len;
          desc_flags = FLAG_W'(FLAG_DATA);
          ptr_d      = ptr_q + SLOT_W'(1);
        end
      end
      default: state_d = SGB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q     <= SGB_IDLE;
      base_q      <= '0;
      rem_q       <= '0;
      offs_q      <= '0;
      pg_left_q   <= '0;
      grp_q       <= '0;
      ptr_q       <= '0;
      prev_end_q  <= '0;
      have_prev_q <= 1'b0;
      done        <= 1'b0;
    end else begin
      state_q     <= state_d;
      base_q      <= base_d;
      rem_q       <= rem_d;
      offs_q      <= offs_d;
      pg_left_q   <= pg_left_d;
      grp_q       <= grp_d;
      ptr_q       <= ptr_d;
      prev_end_q  <= prev_end_d;
      have_prev_q <= have_prev_d;
      done        <= done_d;
    end
  end
endmodule

// File: rtl/sg_list_builder_chk.sv
module sg_list_builder_chk #(
  parameter int          ADDR_W     = 64,
  parameter int          LEN_W      = 32,
  parameter int          FLAG_W     = 32,
  parameter int          IDX_W      = 9,
  parameter int          GRP_N      = 8,
  parameter logic [31:0] FLAG_DATA  = 32'h1,
  parameter logic [31:0] FLAG_CHAIN = 32'h2,
  parameter logic [31:0] FLAG_END   = 32'h4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_ready,
  input logic              desc_we,
  input logic [IDX_W-1:0]  desc_idx,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [LEN_W-1:0]  desc_len,
  input logic [FLAG_W-1:0] desc_flags,
  input logic              done
);
  localparam int GRP_BYTES = GRP_N * 16;

  AST_CHAIN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_flags == FLAG_W'(FLAG_CHAIN)) |->
      (desc_len == LEN_W'(GRP_BYTES) && (desc_idx % GRP_N) == 0)); // R4
  AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_flags == FLAG_W'(FLAG_END)) |->
      (desc_addr == '0 && desc_len == '0)); // R7
  AST_DATA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_flags == FLAG_W'(FLAG_DATA)) |-> (desc_len != '0)); // R2
  AST_END_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_flags == FLAG_W'(FLAG_END)) |=> done); // R9
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(desc_we && desc_flags == FLAG_W'(FLAG_END))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!desc_we && !pg_ready)); // R1
endmodule

bind sg_list_builder sg_list_builder_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W), .GRP_N(GRP_N),
  .FLAG_DATA(FLAG_DATA), .FLAG_CHAIN(FLAG_CHAIN), .FLAG_END(FLAG_END)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_ready(pg_ready), .desc_we(desc_we),
  .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_len(desc_len),
  .desc_flags(desc_flags), .done(done)
);

// File: tb/tb_sg_list_builder.sv
module tb_sg_list_builder;
  localparam int PG = 4096;
  localparam logic [63:0] BASE = 64'h0000_0000_8000_0000;
  localparam logic [63:0] A0   = 64'h0000_0001_0000_0000;

  // {first offset, size, page pattern}: 0 contiguous, 1 scattered,
  // 2 contiguous pairs, 3 seven scattered then contiguous
  localparam int NV = 11;
  localparam int VEC [NV][3] = '{
    '{0,    3*PG,  1},  // R2 three separate fragments
    '{100,  10000, 1},  // R2 offset first page
    '{0,    9*PG,  1},  // R4 one chained group plus final
    '{0,    7*PG,  1},  // R6 exactly seven fragments
    '{0,    8*PG,  2},  // R3 pairwise merge
    '{200,  50000, 0},  // R3 everything merges
    '{4095, 2,     1},  // R2 one byte in each of two pages
    '{0,    15*PG, 1},  // R4 two chained groups
    '{0,    14*PG, 1},  // R6 second group full
    '{4000, 16*PG, 2},  // R3 offset and pair merges
    '{0,    8*PG,  3}   // R6 merge into a full group
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, pg_valid = 1'b0;
  logic [63:0] cfg_list_base = '0, pg_addr = '0;
  logic [11:0] cfg_first_offs = '0;
  logic [19:0] cfg_total_size = '0;
  logic        pg_ready, desc_we, done;
  logic [8:0]  desc_idx;
  logic [63:0] desc_addr;
  logic [31:0] desc_len, desc_flags;

  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  sg_list_builder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_list_base(cfg_list_base),
    .cfg_first_offs(cfg_first_offs), .cfg_total_size(cfg_total_size),
    .pg_valid(pg_valid), .pg_addr(pg_addr), .pg_ready(pg_ready),
    .desc_we(desc_we), .desc_idx(desc_idx), .desc_addr(desc_addr),
    .desc_len(desc_len), .desc_flags(desc_flags), .done(done)
  );

  logic [63:0] m_addr [64];
  logic [31:0] m_len  [64];
  logic [31:0] m_flag [64];
  logic [63:0] e_addr [64];
  logic [31:0] e_len  [64];
  logic [31:0] e_flag [64];
  int          e_cnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] page_of(int kind, int i);
    case (kind)
      0: return A0 + 64'(i) * PG;
      1: return A0 + 64'(2 * i) * PG;
      2: return A0 + 64'((i / 2) * 3 + (i % 2)) * PG;
      default: return A0 + 64'((i < 7) ? 2 * i : i + 6) * PG;
    endcase
  endfunction

  function automatic int page_count(int offs, int size);
    return (size == 0) ? 0 : (offs + size + PG - 1) / PG;
  endfunction

  task automatic build_expected(int offs, int size, int kind);
    logic [63:0] fa [64];
    logic [31:0] fl [64];
    logic [63:0] fend = '0;
    int n = 0, rem = size, nf, k;
    for (int p = 0; p < page_count(offs, size); p++) begin
      int o = (p == 0) ? offs : 0;
      logic [63:0] a = page_of(kind, p) + 64'(o);
      int l = (rem < PG - o) ? rem : PG - o;
      if (n > 0 && a == fend) fl[n-1] = fl[n-1] + 32'(l);
      else begin fa[n] = a; fl[n] = 32'(l); n++; end
      fend = a + 64'(l);
      rem -= l;
    end
    nf = (n == 0) ? 0 : (n - 1) / 7;
    for (int g = 0; g < nf; g++) begin
      e_addr[g*8] = BASE + 64'(128 * (g + 1));
      e_len[g*8]  = 32'd128;
      e_flag[g*8] = 32'h2;
      for (int s = 0; s < 7; s++) begin
        e_addr[g*8+1+s] = fa[g*7+s];
        e_len[g*8+1+s]  = fl[g*7+s];
        e_flag[g*8+1+s] = 32'h1;
      end
    end
    k = n - 7 * nf;
    for (int s = 0; s < k; s++) begin
      e_addr[nf*8+s] = fa[nf*7+s];
      e_len[nf*8+s]  = fl[nf*7+s];
      e_flag[nf*8+s] = 32'h1;
    end
    e_addr[nf*8+k] = '0;
    e_len[nf*8+k]  = '0;
    e_flag[nf*8+k] = 32'h4;
    e_cnt = nf * 8 + k + 1;
  endtask

  task automatic run_case(int offs, int size, int kind, bit inject, string tag);
    int consumed = 0, writes = 0;
    bit got_done = 0, bad_idx = 0;
    for (int i = 0; i < 64; i++) begin
      m_addr[i] = '1; m_len[i] = '1; m_flag[i] = '1;
    end
    build_expected(offs, size, kind);
    for (int cyc = 0; cyc < 3000 && !got_done; cyc++) begin
      @(negedge clk);
      start          = (cyc == 0) || (inject && cyc == 4);
      cfg_list_base  = BASE;
      cfg_first_offs = (inject && cyc == 4) ? 12'd7 : 12'(offs);
      cfg_total_size = (inject && cyc == 4) ? 20'd1 : 20'(size);
      pg_valid       = (cyc > 0);
      pg_addr        = page_of(kind, consumed);
      #1;
      if (pg_valid && pg_ready) consumed++;
      if (desc_we) begin
        writes++;
        if (desc_idx < 64) begin
          m_addr[desc_idx] = desc_addr;
          m_len[desc_idx]  = desc_len;
          m_flag[desc_idx] = desc_flags;
        end else bad_idx = 1;
      end
      if (done) got_done = 1;
    end
    @(negedge clk);
    start = 0; pg_valid = 0;
    chk(got_done, "R9", {tag, " done seen"}, 64'(got_done), 64'd1);
    chk(consumed == page_count(offs, size), "R1", {tag, " pages taken"},
        64'(consumed), 64'(page_count(offs, size)));
    chk(writes == e_cnt && !bad_idx, "R5", {tag, " descriptor writes"},
        64'(writes), 64'(e_cnt));
    for (int i = 0; i < e_cnt; i++) begin
      string rq = (e_flag[i] == 32'h2) ? "R4" : (e_flag[i] == 32'h4) ? "R7" : "R2/R3";
      chk(m_addr[i] == e_addr[i], rq, $sformatf("%s idx %0d addr", tag, i), m_addr[i], e_addr[i]);
      chk(m_len[i] == e_len[i], rq, $sformatf("%s idx %0d len", tag, i), 64'(m_len[i]), 64'(e_len[i]));
      chk(m_flag[i] == e_flag[i], rq, $sformatf("%s idx %0d flags", tag, i), 64'(m_flag[i]), 64'(e_flag[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    pg_valid = 1;
    #1;
    chk(!desc_we && !done && !pg_ready, "R10", "outputs in reset",
        {61'd0, desc_we, done, pg_ready}, 64'd0);
    pg_valid = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!pg_ready, "R1", "ready while idle", 64'(pg_ready), 64'd0);

    for (int v = 0; v < NV; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, $sformatf("vec%0d", v));

    run_case(300, 0, 1, 1'b0, "R8 empty transfer");
    run_case(0, 9 * PG, 1, 1'b1, "R9 start during run");
    run_case(0, 3 * PG, 0, 1'b0, "R3 single merged span");

    repeat (2) @(negedge clk);
    chk(!done && !pg_ready, "R9", "quiet after runs", {62'd0, done, pg_ready}, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule